// File: doc/BRIEF.md
# Strobe-Gated Receive Frame Manager

This block is the receive-side frame controller that sits between a demodulated serial bit stream and a host serial port. An external strobe level wakes it. While the strobe stays high it hunts the incoming bits for a programmed identifier, then for a programmed header. After that it forwards the payload to the host as serial-master data with a clock, and it stops when a programmed end-of-message pattern appears. Both the identifier and the header are accepted either as programmed or with every bit inverted. When the inverted header was seen, the payload and the end-of-message test are corrected, so the host always receives bits in true polarity.

The strobe passes through a two-flop synchronizer. Dropping the strobe at any point aborts the frame at once and deselects the host port. Bits arrive as `rx_bit_i` qualified by a one-cycle `rx_valid_i` pulse. Successive pulses are at least two clock cycles apart. Pattern widths are set by parameters. Patterns are compared most recent bit last, with the earliest received bit in the MSB.

Top module: `strobe_frame_rx`

## Requirements
- R1: Out of reset `state_o` is 0 (standby), `spi_cs_no` is 1, `spi_sck_o` is 0, `spi_sdo_o` is 0 and `inv_o` is 0.
- R2: A high `strobe_i` moves the block from standby (`state_o`=0) to identifier hunt (`state_o`=1) on the third rising clock edge after it is first sampled. While in standby the block never goes to any state other than 0 or 1.
- R3: When `strobe_i` goes low in state 1, 2 or 3, the block is in state 0 three cycles later, with `spi_cs_no`=1 and `spi_sck_o`=0. While the strobe is low, incoming bits do not change the state.
- R4: In state 1, when the last ID_W valid bits equal `id_pat_i` or its bitwise complement, the block goes to header hunt (`state_o`=2). Any other bit sequence leaves it in state 1.
- R5: In state 2, a match of the last HDR_W valid bits against `hdr_pat_i` enters data state (`state_o`=3) with `inv_o`=0. A match against its complement enters state 3 with `inv_o`=1. State 3 is entered only from state 2, and `inv_o` stays constant while in state 3.
- R6: In state 3, each received payload bit XOR `inv_o` is sent out on `spi_sdo_o` in arrival order, with one single-cycle `spi_sck_o` pulse per bit. `spi_sdo_o` is set one cycle before the rising clock edge and is held while the clock is high.
- R7: When the last EOM_W payload bits, after polarity correction, equal `eom_pat_i`, the frame ends and none of those EOM_W bits is forwarded. If the strobe is still high, the block returns to state 1.
- R8: `spi_cs_no` is low in state 3, and after an end-of-message until the last clock pulse completes. It is high at all other times, and `spi_sck_o` is never high while `spi_cs_no` is high.
- R9: `rx_bit_i` is ignored in any cycle where `rx_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Asynchronous enable level |
| rx_bit_i | input | 1 | Recovered data bit |
| rx_valid_i | input | 1 | One-cycle qualifier for rx_bit_i |
| id_pat_i | input | ID_W | Identifier pattern |
| hdr_pat_i | input | HDR_W | Header pattern |
| eom_pat_i | input | EOM_W | End-of-message pattern (true polarity) |
| spi_sdo_o | output | 1 | Serial data to host |
| spi_sck_o | output | 1 | Serial clock to host |
| spi_cs_no | output | 1 | Active-low select to host |
| state_o | output | 2 | 0 standby, 1 ID hunt, 2 header hunt, 3 data |
| inv_o | output | 1 | Inverted header latched |

## Verification
The hardest case to reach is a frame in inverted polarity. For it, the identifier, the header, the payload and the end pattern must all arrive complemented, and the host must still see true data with the terminating bits removed. The bench drives a complete inverted frame right after a true one, without dropping the strobe. This also shows that the end of the first frame returns the block cleanly to identifier hunt. Abort while the strobe is low is exercised from each active state, the data state included.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID   = 2'd1,
    ST_HDR  = 2'd2,
    ST_DATA = 2'd3
  } sfr_state_e;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfr_matcher.sv
// Shift-register pattern hunt; hit flags refer to the post-shift contents.
module sfr_matcher #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic [W-1:0] pat_i,
  output logic         hit_true_o,
  output logic         hit_comp_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sr_nxt;
  logic          full_nxt;

  assign sr_nxt   = {sr_q[W-2:0], bit_i};
  assign full_nxt = (cnt_q >= CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q <= sr_nxt;
      if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_true_o = shift_i && full_nxt && (sr_nxt == pat_i);
  assign hit_comp_o = shift_i && full_nxt && (sr_nxt == ~pat_i);
endmodule

// File: rtl/sfr_eom_window.sv
// Delay window: a bit leaves toward the host only after EOM_W newer bits
// have shown it cannot belong to the terminating pattern.
module sfr_eom_window #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic [W-1:0] pat_i,
  output logic         hit_o,
  output logic         lead_vld_o,
  output logic         lead_bit_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  win_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  win_nxt;

  assign win_nxt = {win_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      win_q <= win_nxt;
      if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o      = shift_i && (cnt_q >= CW'(W - 1)) && (win_nxt == pat_i);
  assign lead_vld_o = shift_i && (cnt_q == CW'(W));
  assign lead_bit_o = win_q[W-1];
endmodule

// File: rtl/sfr_spi_out.sv
module sfr_spi_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic load_i,
  input  logic bit_i,
  output logic sdo_o,
  output logic sck_o,
  output logic busy_o
);
  logic sdo_q, sck_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_q  <= 1'b0;
      sck_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (abort_i) begin
      sdo_q  <= 1'b0;
      sck_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      sdo_q  <= bit_i;
      sck_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      sck_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sck_q  <= 1'b0;
    end
  end

  assign sdo_o  = sdo_q;
  assign sck_o  = sck_q;
  assign busy_o = pend_q | sck_q;
endmodule

// File: rtl/strobe_frame_rx.sv
module strobe_frame_rx
  import sfr_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int HDR_W   = 8,
  parameter int EOM_W   = 8,
  parameter int SYNC_ST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             rx_bit_i,
  input  logic             rx_valid_i,
  input  logic [ID_W-1:0]  id_pat_i,
  input  logic [HDR_W-1:0] hdr_pat_i,
  input  logic [EOM_W-1:0] eom_pat_i,
  output logic             spi_sdo_o,
  output logic             spi_sck_o,
  output logic             spi_cs_no,
  output logic [1:0]       state_o,
  output logic             inv_o
);
  sfr_state_e state_q, state_d;
  logic inv_q, inv_d;
  logic strobe_s;
  logic id_hit_t, id_hit_c, hdr_hit_t, hdr_hit_c, eom_hit;
  logic lead_vld, lead_bit, fwd_load, spi_busy;
  logic in_id, in_hdr, in_data;

  sfr_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(strobe_i), .q_o(strobe_s)
  );

  assign in_id   = (state_q == ST_ID);
  assign in_hdr  = (state_q == ST_HDR);
  assign in_data = (state_q == ST_DATA);

  sfr_matcher #(.W(ID_W)) u_id (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_id),
    .shift_i   (in_id && strobe_s && rx_valid_i),
    .bit_i     (rx_bit_i),
    .pat_i     (id_pat_i),
    .hit_true_o(id_hit_t),
    .hit_comp_o(id_hit_c)
  );

  sfr_matcher #(.W(HDR_W)) u_hdr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_hdr),
    .shift_i   (in_hdr && strobe_s && rx_valid_i),
    .bit_i     (rx_bit_i),
    .pat_i     (hdr_pat_i),
    .hit_true_o(hdr_hit_t),
    .hit_comp_o(hdr_hit_c)
  );

  // window stores polarity-corrected bits
  sfr_eom_window #(.W(EOM_W)) u_eom (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!in_data),
    .shift_i   (in_data && strobe_s && rx_valid_i),
    .bit_i     (rx_bit_i ^ inv_q),
    .pat_i     (eom_pat_i),
    .hit_o     (eom_hit),
    .lead_vld_o(lead_vld),
    .lead_bit_o(lead_bit)
  );

  // the leaving bit is payload even on the cycle the pattern completes
  assign fwd_load = lead_vld;

  sfr_spi_out u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(!strobe_s),
    .load_i (fwd_load),
    .bit_i  (lead_bit),
    .sdo_o  (spi_sdo_o),
    .sck_o  (spi_sck_o),
    .busy_o (spi_busy)
  );

  always_comb begin
    state_d = state_q;
    inv_d   = inv_q;
    unique case (state_q)
      ST_IDLE: if (strobe_s) state_d = ST_ID;
      ST_ID: begin
        if (!strobe_s)                 state_d = ST_IDLE;
        else if (id_hit_t || id_hit_c) state_d = ST_HDR;
      end
      ST_HDR: begin
        if (!strobe_s) state_d = ST_IDLE;
        else if (hdr_hit_t || hdr_hit_c) begin
          state_d = ST_DATA;
          inv_d   = hdr_hit_c;
        end
      end
      ST_DATA: begin
        if (!strobe_s)    state_d = ST_IDLE;
        else if (eom_hit) state_d = ST_ID;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      inv_q   <= inv_d;
    end
  end

  assign spi_cs_no = !(in_data || spi_busy);
  assign state_o   = state_q;
  assign inv_o     = inv_q;
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic       spi_sdo_o,
  input logic       spi_sck_o,
  input logic       spi_cs_no,
  input logic [1:0] state_o,
  input logic       inv_o
);
  // R3
  strobe_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i, 3) |-> (state_o == 2'd0 && spi_cs_no && !spi_sck_o));

  // R2
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1));

  // R5
  data_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && $past(state_o) != 2'd3) |-> ($past(state_o) == 2'd2));

  // R5
  inv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && $past(state_o) == 2'd3) |-> $stable(inv_o));

  // R6
  sck_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |=> !spi_sck_o);

  // R6
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_sdo_o));

  // R8
  sck_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> !spi_cs_no);
endmodule

bind strobe_frame_rx sfr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .spi_sdo_o(spi_sdo_o),
  .spi_sck_o(spi_sck_o),
  .spi_cs_no(spi_cs_no),
  .state_o  (state_o),
  .inv_o    (inv_o)
);

// File: tb/strobe_frame_rx_bench.sv
module strobe_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ID  = 16'hA5C3;
  localparam logic [7:0]  HDR = 8'h7E;
  localparam logic [7:0]  EOM = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic rx_bit = 1'b0;
  logic rx_valid = 1'b0;
  logic sdo, sck, cs_n, inv;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rx_data = '0;
  int rx_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_frame_rx u_strobe_frame_rx (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .strobe_i  (strobe),
    .rx_bit_i  (rx_bit),
    .rx_valid_i(rx_valid),
    .id_pat_i  (ID),
    .hdr_pat_i (HDR),
    .eom_pat_i (EOM),
    .spi_sdo_o (sdo),
    .spi_sck_o (sck),
    .spi_cs_no (cs_n),
    .state_o   (state),
    .inv_o     (inv)
  );

  always @(posedge sck) begin
    rx_data <= {rx_data[30:0], sdo};
    rx_cnt  <= rx_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); rx_bit = v[i]; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic strobe_on();
    @(negedge clk); strobe = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_off();
    @(negedge clk); strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sck", sck, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 inv", inv, 0);
  endtask

  task automatic t_idle_ignores();
    send_bits(32'(ID), 16);
    chk("R3 bits ignored with strobe low", state, 0);
  endtask

  task automatic t_strobe_timing();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 still idle after two edges", state, 0);
    @(negedge clk);
    chk("R2 id hunt on third edge", state, 1);
  endtask

  task automatic t_wrong_id();
    send_bits(32'h1111, 16);
    chk("R4 wrong id stays", state, 1);
    strobe_off();
    chk("R3 abort from id hunt", state, 0);
  endtask

  task automatic t_invalid_ignored();
    strobe_on();
    send_bits(32'(ID[15:8]), 8);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); rx_bit = ~rx_bit;
    end
    send_bits(32'(ID[7:0]), 8);
    chk("R9 id match across unqualified bits", state, 2);
    strobe_off();
    chk("R3 abort from header hunt", state, 0);
    chk("R3 cs_n after abort", cs_n, 1);
  endtask

  task automatic t_frame(input bit comp, input logic [15:0] payload, input string tag);
    int base;
    logic [15:0] msk;
    msk = comp ? 16'hFFFF : 16'h0000;
    send_bits(32'(ID ^ msk), 16);
    chk({tag, " R4 id match"}, state, 2);
    send_bits(32'(HDR ^ msk[7:0]), 8);
    chk({tag, " R5 data state"}, state, 3);
    chk({tag, " R5 polarity"}, inv, 32'(comp));
    chk({tag, " R8 cs_n low in data"}, cs_n, 0);
    base = rx_cnt;
    send_bits(32'(payload ^ msk), 16);
    send_bits(32'(EOM ^ msk[7:0]), 8);
    repeat (6) @(negedge clk);
    chk({tag, " R7 back to id hunt"}, state, 1);
    chk({tag, " R7 pattern bits not forwarded"}, 32'(rx_cnt - base), 16);
    chk({tag, " R6 payload true polarity"}, 32'(rx_data[15:0]), 32'(payload));
    chk({tag, " R8 cs_n high after frame"}, cs_n, 1);
  endtask

  task automatic t_abort_data();
    int base;
    send_bits(32'(ID), 16);
    send_bits(32'(HDR), 8);
    base = rx_cnt;
    send_bits(32'h0000_0F5A, 12);
    chk("R6 bits forwarded before abort", 32'(rx_cnt - base), 4);
    @(negedge clk); strobe = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 data held two edges", state, 3);
    @(negedge clk);
    chk("R3 abort from data", state, 0);
    chk("R3 cs_n after data abort", cs_n, 1);
    chk("R3 sck low after data abort", sck, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_ignores();
    t_strobe_timing();
    t_wrong_id();
    t_invalid_ignored();
    strobe_on();
    t_frame(1'b0, 16'h1234, "true");
    t_frame(1'b1, 16'hC3A0, "comp");
    t_abort_data();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule